// File: doc/BRIEF.md
# Two-Key Held Reset Generator

This block turns two ordinary active-low key inputs into a deliberate hardware reset. A reset is only produced when both keys are held down together without a break for a setup delay of 2, 6 or 10 seconds. The delay is chosen at run time. Time is measured by counting pulses on a tick-enable input whose period is known, so `TICKS_PER_SEC` ticks make one second. While the hold is being timed, an early-warning output lets a processor prepare for the coming reset. When the delay runs out, the active-low reset output asserts. In fixed mode the pulse lasts `REC_TICKS` ticks. In held mode it lasts as long as both keys stay down.

An undervoltage flag from an external comparator overrides everything. It forces reset at once and keeps it asserted until the flag clears, then for a further `REC_TICKS` ticks. With `POR_EN` set, the same recovery hold is applied after the block's reset is released. Key inputs are assumed to be synchronised and debounced already.

The controller is a state machine with six states:
- `S_IDLE`: waiting for a press.
- `S_ARMED`: both keys are held and the delay is being timed.
- `S_PULSE`: fixed-length reset.
- `S_HELD`: key-controlled reset.
- `S_RECOVER`: undervoltage or power-on hold plus the recovery time.
- `S_LOCK`: fixed pulse has finished and the block waits for the keys to be let go.

The transitions are:
- From any state to `S_RECOVER` whenever the flag is high.
- `S_IDLE` to `S_ARMED` when both keys are low.
- `S_ARMED` to `S_IDLE` when either key rises.
- `S_ARMED` to `S_PULSE` (fixed mode) or `S_HELD` (held mode) when the delay completes.
- `S_PULSE` to `S_LOCK` after the recovery ticks.
- `S_HELD` to `S_IDLE` when either key rises.
- `S_LOCK` to `S_IDLE` when both keys are high.
- `S_RECOVER` to `S_IDLE` after the recovery ticks have elapsed with the flag low.

Top module: `dual_key_reset_ctrl`

## Requirements
- R1: Counting starts at the clock edge where both keys are first sampled low together. That edge's tick is not counted. `rst_out_n` falls on the edge that carries the N-th counted tick, where N = seconds × `TICKS_PER_SEC`.
- R2: `delay_sel` selects the number of seconds: 2'b00 = 2 s, 2'b01 = 6 s, 2'b10 = 10 s, and 2'b11 = 10 s.
- R3: With `hold_mode` = 0, the reset pulse lasts exactly `REC_TICKS` counted ticks and then `rst_out_n` returns high. Key activity during the pulse has no effect.
- R4: If either key is sampled high before the delay completes, no reset is produced and the count clears. A later press starts again from zero.
- R5: With `hold_mode` = 1 (sampled at the completion edge), `rst_out_n` stays low while both keys are held. It goes high on the edge where either key is sampled high.
- R6: When `uv_flag` is sampled high, `rst_out_n` is low after that edge whatever the state. It stays low while the flag is high, and for `REC_TICKS` counted ticks after the flag is first sampled low; that first edge's tick counts.
- R7: With `POR_EN` = 1, `rst_out_n` stays low after `arst_n` releases until `REC_TICKS` ticks have been counted with `uv_flag` low.
- R8: `warn_out` is high exactly while the delay is being timed. It goes low on the edge where reset asserts or either key is released, and it is never high while reset is asserted.
- R9: After a fixed-mode pulse, no new reset starts until both keys have been sampled high together. Holding the keys down does not retrigger.
- R10: While `arst_n` is low, `warn_out` = 0 and `rst_out_n` = !`POR_EN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| tick_en | input | 1 | Time-base tick, one clock wide |
| key_a_n | input | 1 | First key, low = pressed |
| key_b_n | input | 1 | Second key, low = pressed |
| delay_sel | input | 2 | Setup delay choice |
| hold_mode | input | 1 | 0 = fixed pulse, 1 = pulse follows keys |
| uv_flag | input | 1 | Undervoltage indication, high = low supply |
| warn_out | output | 1 | Early warning, high while hold is timed |
| rst_out_n | output | 1 | Active-low reset output |

## Verification
Both outputs are registered from the next state, so each reaction is due right after the edge that samples its cause. This covers the undervoltage override, a key release and the terminal tick. The bench drives inputs on falling edges and compares both outputs on every falling edge against a bench reference model advanced on the rising edge, so each result is seen half a cycle after it is due. Directed runs with a tick on every clock count falling edges from a press to the reset fall. They expect N+1, because the arming edge is the first one counted, and they expect `REC_TICKS` from release of block reset to the end of the power-on hold.

// File: rtl/drst_pkg.sv
package drst_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_PULSE,
        S_HELD,
        S_RECOVER,
        S_LOCK
    } drst_state_e;

    function automatic int unsigned sel_seconds(input logic [1:0] sel);
        unique case (sel)
            2'b00:   sel_seconds = 2;
            2'b01:   sel_seconds = 6;
            default: sel_seconds = 10;
        endcase
    endfunction
endpackage

// File: rtl/drst_tick_timer.sv
module drst_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (run_i && tick_i && (cnt_q != {CW{1'b1}}))
            cnt_q <= cnt_q + 1'b1;
    end

    // terminal tick: this tick brings the count up to the limit (or past a shrunken one)
    always_comb
        done_o = run_i && tick_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i});

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!arst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/drst_fsm.sv
module drst_fsm
    import drst_pkg::*;
#(
    parameter bit POR_EN = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic both_held_i,
    input  logic both_free_i,
    input  logic hold_mode_i,
    input  logic uv_i,
    input  logic done_i,
    output logic run_o,
    output logic use_rec_o,
    output logic clr_o,
    output logic warn_o,
    output logic rst_n_o
);
    localparam drst_state_e RESET_STATE = POR_EN ? S_RECOVER : S_IDLE;

    drst_state_e st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        if (uv_i) begin
            st_nx = S_RECOVER;
        end else begin
            unique case (st_q)
                S_IDLE:    if (both_held_i) st_nx = S_ARMED;
                S_ARMED: begin
                    if (!both_held_i)   st_nx = S_IDLE;
                    else if (done_i)    st_nx = hold_mode_i ? S_HELD : S_PULSE;
                end
                S_PULSE:   if (done_i) st_nx = S_LOCK;
                S_HELD:    if (!both_held_i) st_nx = S_IDLE;
                S_RECOVER: if (done_i) st_nx = S_IDLE;
                S_LOCK:    if (both_free_i) st_nx = S_IDLE;
                default:   st_nx = S_IDLE;
            endcase
        end
    end

    always_comb begin
        run_o     = (st_q == S_ARMED) || (st_q == S_PULSE) || (st_q == S_RECOVER);
        use_rec_o = (st_q == S_PULSE) || (st_q == S_RECOVER);
        clr_o     = (st_nx != st_q) || uv_i;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            st_q <= RESET_STATE;
        else
            st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rst_n_o <= !POR_EN;
            warn_o  <= 1'b0;
        end else begin
            rst_n_o <= !((st_nx == S_PULSE) || (st_nx == S_HELD) || (st_nx == S_RECOVER));
            warn_o  <= (st_nx == S_ARMED);
        end
    end

    p_uv_forces_r6: assert property (@(posedge clk) disable iff (!arst_n)
        uv_i |=> !rst_n_o);
    p_warn_excl_r8: assert property (@(posedge clk) disable iff (!arst_n)
        !(warn_o && !rst_n_o));
    p_release_aborts_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q == S_ARMED && !both_held_i && !uv_i) |=> (rst_n_o && !warn_o));
    p_hold_release_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q == S_HELD && !both_held_i && !uv_i) |=> rst_n_o);
    p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q == S_LOCK && !uv_i) |=> rst_n_o);
endmodule

// File: rtl/dual_key_reset_ctrl.sv
module dual_key_reset_ctrl
    import drst_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 100,
    parameter int unsigned REC_TICKS     = 20,
    parameter bit          POR_EN        = 1'b1
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       tick_en,
    input  logic       key_a_n,
    input  logic       key_b_n,
    input  logic [1:0] delay_sel,
    input  logic       hold_mode,
    input  logic       uv_flag,
    output logic       warn_out,
    output logic       rst_out_n
);
    localparam int unsigned MAX_DLY = 10 * TICKS_PER_SEC;
    localparam int unsigned MAX_LIM = (MAX_DLY > REC_TICKS) ? MAX_DLY : REC_TICKS;
    localparam int CW = $clog2(MAX_LIM + 2);

    logic          both_held, both_free;
    logic          run, use_rec, clr, done;
    logic [CW-1:0] dly_limit, limit;

    always_comb begin
        both_held = !key_a_n && !key_b_n;
        both_free = key_a_n && key_b_n;
        dly_limit = CW'(sel_seconds(delay_sel) * TICKS_PER_SEC);
        limit     = use_rec ? CW'(REC_TICKS) : dly_limit;
    end

    drst_tick_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .arst_n  (arst_n),
        .clr_i   (clr),
        .run_i   (run),
        .tick_i  (tick_en),
        .limit_i (limit),
        .done_o  (done)
    );

    drst_fsm #(.POR_EN(POR_EN)) u_fsm (
        .clk         (clk),
        .arst_n      (arst_n),
        .both_held_i (both_held),
        .both_free_i (both_free),
        .hold_mode_i (hold_mode),
        .uv_i        (uv_flag),
        .done_i      (done),
        .run_o       (run),
        .use_rec_o   (use_rec),
        .clr_o       (clr),
        .warn_o      (warn_out),
        .rst_n_o     (rst_out_n)
    );
endmodule

// File: tb/sim_dual_key_reset_ctrl.sv
`timescale 1ns/1ps
module sim_dual_key_reset_ctrl;
    localparam int TPS = 5;
    localparam int REC = 7;

    localparam int M_IDLE = 0, M_ARMED = 1, M_PULSE = 2, M_HELD = 3, M_RECOVER = 4, M_LOCK = 5;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic tick_en = 1'b0;
    logic key_a_n = 1'b1, key_b_n = 1'b1;
    logic [1:0] delay_sel = 2'b00;
    logic hold_mode = 1'b0;
    logic uv_flag = 1'b0;
    logic warn_out, rst_out_n;

    int n_chk = 0;
    int n_bad = 0;
    int ms = M_RECOVER;
    int mc = 0;
    logic er = 1'b0, ew = 1'b0;

    always #2.5 clk = ~clk;

    dual_key_reset_ctrl #(.TICKS_PER_SEC(TPS), .REC_TICKS(REC), .POR_EN(1'b1)) u0 (
        .clk(clk), .arst_n(arst_n), .tick_en(tick_en), .key_a_n(key_a_n), .key_b_n(key_b_n),
        .delay_sel(delay_sel), .hold_mode(hold_mode), .uv_flag(uv_flag),
        .warn_out(warn_out), .rst_out_n(rst_out_n)
    );

    // R2: 00 = 2 s, 01 = 6 s, 10/11 = 10 s
    function automatic int exp_limit(input logic [1:0] s);
        if (s == 2'b00) return 2 * TPS;
        if (s == 2'b01) return 6 * TPS;
        return 10 * TPS;
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            M_ARMED:   return "R1";
            M_PULSE:   return "R3";
            M_HELD:    return "R5";
            M_RECOVER: return "R6";
            M_LOCK:    return "R9";
            default:   return "R4";
        endcase
    endfunction

    // reference model, advanced on the rising edge from inputs driven on the falling edge
    always @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ms = M_RECOVER; mc = 0; er = 1'b0; ew = 1'b0;
        end else begin
            automatic bit both = !key_a_n && !key_b_n;
            automatic bit free = key_a_n && key_b_n;
            automatic int lim = (ms == M_PULSE || ms == M_RECOVER) ? REC : exp_limit(delay_sel);
            automatic bit run = (ms == M_ARMED || ms == M_PULSE || ms == M_RECOVER);
            automatic bit dn = run && tick_en && (mc + 1 >= lim);
            automatic int nx = ms;
            if (uv_flag) nx = M_RECOVER;
            else case (ms)
                M_IDLE:    if (both) nx = M_ARMED;
                M_ARMED:   if (!both) nx = M_IDLE; else if (dn) nx = hold_mode ? M_HELD : M_PULSE;
                M_PULSE:   if (dn) nx = M_LOCK;
                M_HELD:    if (!both) nx = M_IDLE;
                M_RECOVER: if (dn) nx = M_IDLE;
                default:   if (free) nx = M_IDLE;
            endcase
            if (nx != ms || uv_flag) mc = 0;
            else if (run && tick_en) mc = mc + 1;
            ms = nx;
            er = !(ms == M_PULSE || ms == M_HELD || ms == M_RECOVER);
            ew = (ms == M_ARMED);
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check(tag_of(ms), rst_out_n, er, "rst_out_n");
        check("R8", warn_out, ew, "warn_out");
    endtask

    task automatic settle_idle();
        key_a_n = 1'b1; key_b_n = 1'b1; uv_flag = 1'b0; tick_en = 1'b1;
        repeat (REC + 3) cyc();
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        #1;
        check("R10", rst_out_n, 1'b0, "rst_out_n in reset");
        check("R10", warn_out, 1'b0, "warn_out in reset");
        repeat (3) @(negedge clk);
        check("R10", rst_out_n, 1'b0, "rst_out_n in reset");

        // R7: power-on hold lasts REC ticks after release
        tick_en = 1'b1;
        arst_n = 1'b1;
        n = 0;
        do begin cyc(); n++; end while (rst_out_n == 1'b0 && n < 100);
        check("R7", (n == REC), 1'b1, "power-on hold length matches");

        // R2/R1: measured delay for each select code, fixed mode
        for (int s = 0; s < 4; s++) begin
            settle_idle();
            delay_sel = 2'(s); hold_mode = 1'b0;
            key_a_n = 1'b0; key_b_n = 1'b0;
            n = 0;
            do begin cyc(); n++; end while (rst_out_n == 1'b1 && n < 200);
            check("R2", (n == exp_limit(2'(s)) + 1), 1'b1, "delay length matches select");
            // R3 pulse length, keys still held; R9 no retrigger while held
            n = 0;
            do begin cyc(); n++; end while (rst_out_n == 1'b0 && n < 100);
            check("R3", (n == REC), 1'b1, "pulse length");
            repeat (exp_limit(2'(s)) + 5) cyc();
            check("R9", rst_out_n, 1'b1, "no retrigger while held");
            key_a_n = 1'b1;
            repeat (exp_limit(2'(s)) + 5) cyc();
            check("R9", rst_out_n, 1'b1, "one key released is not enough");
        end

        // R4: release one cycle before completion, then full re-press
        settle_idle();
        delay_sel = 2'b00;
        key_a_n = 1'b0; key_b_n = 1'b0;
        repeat (2 * TPS - 1) cyc();
        key_b_n = 1'b1;
        cyc();
        check("R4", rst_out_n, 1'b1, "early release gives no reset");
        check("R4", warn_out, 1'b0, "early release drops warning");
        key_b_n = 1'b0;
        n = 0;
        do begin cyc(); n++; end while (rst_out_n == 1'b1 && n < 200);
        check("R4", (n == 2 * TPS + 1), 1'b1, "count restarted from zero");

        // R5: held mode
        settle_idle();
        hold_mode = 1'b1; key_a_n = 1'b0; key_b_n = 1'b0;
        repeat (2 * TPS + 1 + 40) cyc();
        check("R5", rst_out_n, 1'b0, "reset held while keys down");
        key_a_n = 1'b1;
        cyc();
        check("R5", rst_out_n, 1'b1, "released on key rise");

        // R6: undervoltage in the middle of arming
        settle_idle();
        key_a_n = 1'b0; key_b_n = 1'b0;
        repeat (3) cyc();
        uv_flag = 1'b1;
        cyc();
        check("R6", rst_out_n, 1'b0, "undervoltage forces reset");
        repeat (10) cyc();
        key_a_n = 1'b1; key_b_n = 1'b1; uv_flag = 1'b0;
        n = 0;
        do begin cyc(); n++; end while (rst_out_n == 1'b0 && n < 100);
        check("R6", (n == REC), 1'b1, "recovery length after flag clears");

        // random mixed stimulus against the reference model
        for (int i = 0; i < 4000; i++) begin
            automatic int r = $urandom % 100;
            tick_en = ($urandom % 3) != 0;
            if (r < 4) key_a_n = ~key_a_n;
            else if (r < 8) key_b_n = ~key_b_n;
            else if (r < 10) begin key_a_n = 1'b0; key_b_n = 1'b0; end
            else if (r < 11) delay_sel = 2'($urandom % 4);
            else if (r < 12) hold_mode = ~hold_mode;
            if (($urandom % 400) == 0) uv_flag = 1'b1;
            else if (uv_flag && ($urandom % 8) == 0) uv_flag = 1'b0;
            cyc();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule